// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block turns a host's direction and pulse-width inputs into four gate enables for a full H-bridge. The bridge has a high and a low switch on side 1 and the same pair on side 2. For each direction, one high-side switch stays on. On the other side, the high and low switches alternate, the low switch following the pulse input. Every gate turn-on waits a programmable number of clock cycles. Every turn-off happens at the next clock edge. This way the two switches of one leg are never on together.

A global enable forces all gates off. Each switch has a desaturation comparator bit. That bit is only trusted after the switch has been on for a blanking interval. A qualified short then holds every gate off, and raises the fault flag, until the pulse input next changes level. A supply-low indication drops all gates at once, with no blanking. It holds the fault flag only while the indication lasts. The direction, pulse, desaturation and supply-low inputs pass through two-flop synchronizers. All outputs come from registers.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `enable` is low, all four gate outputs are 0, whatever `dir` and `pwm` do.
- R2: With `enable` high and `dir`=0, the gates settle to hs1=1, ls1=0, hs2=~pwm, ls2=pwm.
- R3: With `enable` high and `dir`=1, the gates settle to hs1=~pwm, ls1=pwm, hs2=1, ls2=0.
- R4: A gate rises 3+`deadCycles` clock edges after the input change that requests it. It falls 3 edges after the change that releases it. hs1 and ls1 are never 1 together, and neither are hs2 and ls2.
- R5: A change of `dir` alone also starts the dead-time delay for the gates that it turns on.
- R6: `deadCycles`=0 inserts no delay. A `pwm` held high (100% duty) leaves every gate steady, with no transitions.
- R7: A desaturation bit (bit 0 hs1, bit 1 ls1, bit 2 hs2, bit 3 ls2) is ignored while its gate is off. It is also ignored during the first BLANK_CYC cycles that its gate is on. After that, it trips a short.
- R8: A qualified short drives all gates to 0 and `fault` to 1. That state holds through `dir` changes and the removal of the desaturation bit. The first `pwm` level change clears `fault` and restores the gates that `dir` selects.
- R9: `supplyLow` drives all gates to 0 and `fault` to 1 three edges after it rises, with no blanking. Both clear three edges after it falls.
- R10: While `fault` is 1, all gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| enable | input | 1 | Global gate enable |
| dir | input | 1 | Rotation direction from the host |
| pwm | input | 1 | Pulse-width input from the host |
| desat | input | 4 | Desaturation comparator bits {ls2, hs2, ls1, hs1} |
| supplyLow | input | 1 | Bridge supply below its safe level |
| deadCycles | input | DT_W | Turn-on delay in clock cycles |
| hs1 | output | 1 | High-side gate, side 1 |
| ls1 | output | 1 | Low-side gate, side 1 |
| hs2 | output | 1 | High-side gate, side 2 |
| ls2 | output | 1 | Low-side gate, side 2 |
| fault | output | 1 | Short-circuit or supply-low fault flag |

## Verification
The main function is exercised with all four combinations of direction and pulse level. This separates the side that is held on from the side that switches, and tells the two directions apart.

Edge latency is measured separately for pulse and direction changes, at delays of 0, 5 and 12 cycles. This shows that only turn-on is delayed, and that a direction change restarts the delay.

A long 100% duty run watches for any stray output transition. Desaturation is applied to an off switch, inside the blanking window and after it. This tells ignoring, blanking and tripping apart. The latched short is then poked with direction changes before a pulse edge releases it. These cases are contrasted with supply-low, which follows its input.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Gate indices; the desat bit order follows this numbering.
  localparam int GATES = 4;
  localparam int G_HS1 = 0;
  localparam int G_LS1 = 1;
  localparam int G_HS2 = 2;
  localparam int G_LS2 = 3;

  // Strobes from control to the gate datapath.
  typedef struct packed {
    logic [GATES-1:0] want;    // requested gate state before timing
    logic             killAll; // force every gate off now
  } hbg_cmd_t;

  // Requested gate pattern for a direction and pulse level.
  function automatic logic [GATES-1:0] gatePattern(input logic dirLvl, input logic pwmLvl);
    logic [GATES-1:0] p;
    if (!dirLvl) begin
      p[G_HS1] = 1'b1;
      p[G_LS1] = 1'b0;
      p[G_HS2] = ~pwmLvl;
      p[G_LS2] = pwmLvl;
    end else begin
      p[G_HS1] = ~pwmLvl;
      p[G_LS1] = pwmLvl;
      p[G_HS2] = 1'b1;
      p[G_LS2] = 1'b0;
    end
    return p;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
  import hbg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     dirS,
  input  logic     pwmS,
  input  logic     supS,
  input  logic     scHit,
  output hbg_cmd_t cmd,
  output logic     faultQ
);
  logic pwmPrev;
  logic pwmEdge;
  logic scLatch;
  logic scNext;

  assign pwmEdge = pwmS ^ pwmPrev;
  // A new short sets the latch; a pulse edge releases it.
  assign scNext  = scHit | (scLatch & ~pwmEdge);

  always_comb begin
    cmd.want    = enable ? gatePattern(dirS, pwmS) : '0;
    cmd.killAll = scNext | supS;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pwmPrev <= 1'b0;
      scLatch <= 1'b0;
      faultQ  <= 1'b0;
    end else begin
      pwmPrev <= pwmS;
      scLatch <= scNext;
      faultQ  <= scNext | supS;
    end
  end

  // R9: a supply-low indication reaches the flag on the next edge
  p_sup_sets_fault_r9: assert property (@(posedge clk) disable iff (rst)
    supS |=> faultQ);

  // R8: without a pulse edge or supply-low, a latched short keeps the flag
  p_short_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (faultQ && !supS && !pwmEdge && !$past(supS)) |=> faultQ);
endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int DT_W      = 8,
  parameter int BLANK_CYC = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  hbg_cmd_t         cmd,
  input  logic [DT_W-1:0]  deadCycles,
  input  logic [GATES-1:0] desatS,
  output logic [GATES-1:0] gateQ,
  output logic             scHit
);
  localparam int BL_W = $clog2(BLANK_CYC + 1);
  localparam logic [BL_W-1:0] BL_END = BL_W'(BLANK_CYC);

  logic [GATES-1:0] qual;

  for (genvar g = 0; g < GATES; g++) begin : g_gate
    logic [DT_W-1:0] dtCnt;
    logic [BL_W-1:0] blCnt;
    logic            effWant;

    assign effWant = cmd.want[g] & ~cmd.killAll;

    // Turn-off at once; turn-on only after the dead-time count is reached.
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        gateQ[g] <= 1'b0;
        dtCnt    <= '0;
      end else if (!effWant) begin
        gateQ[g] <= 1'b0;
        dtCnt    <= '0;
      end else if (!gateQ[g]) begin
        if (dtCnt >= deadCycles) gateQ[g] <= 1'b1;
        else                     dtCnt    <= dtCnt + 1'b1;
      end
    end

    // Blanking counter runs while the gate is on, saturating at the end.
    always_ff @(posedge clk or posedge rst) begin
      if (rst)              blCnt <= '0;
      else if (!gateQ[g])   blCnt <= '0;
      else if (blCnt != BL_END) blCnt <= blCnt + 1'b1;
    end

    assign qual[g] = gateQ[g] & desatS[g] & (blCnt == BL_END);

    // R7: a gate just switched on cannot report a short in the same cycle
    p_blank_after_on_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(gateQ[g]) |-> !qual[g]);
  end

  assign scHit = |qual;

  // R4: the two switches of a leg are never on together
  p_leg_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(gateQ[G_HS1] && gateQ[G_LS1]) && !(gateQ[G_HS2] && gateQ[G_LS2]));
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int DT_W      = 8,
  parameter int BLANK_CYC = 100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            dir,
  input  logic            pwm,
  input  logic [3:0]      desat,
  input  logic            supplyLow,
  input  logic [DT_W-1:0] deadCycles,
  output logic            hs1,
  output logic            ls1,
  output logic            hs2,
  output logic            ls2,
  output logic            fault
);
  localparam int SYNC_W = GATES + 3;

  logic [SYNC_W-1:0] syncOut;
  logic              dirS;
  logic              pwmS;
  logic              supS;
  logic [GATES-1:0]  desatS;
  logic [GATES-1:0]  gateQ;
  logic              scHit;
  hbg_cmd_t          cmd;

  hbg_sync #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({desat, supplyLow, pwm, dir}),
    .dout (syncOut)
  );

  assign dirS   = syncOut[0];
  assign pwmS   = syncOut[1];
  assign supS   = syncOut[2];
  assign desatS = syncOut[SYNC_W-1:3];

  hbg_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .dirS   (dirS),
    .pwmS   (pwmS),
    .supS   (supS),
    .scHit  (scHit),
    .cmd    (cmd),
    .faultQ (fault)
  );

  hbg_datapath #(.DT_W(DT_W), .BLANK_CYC(BLANK_CYC)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .deadCycles (deadCycles),
    .desatS     (desatS),
    .gateQ      (gateQ),
    .scHit      (scHit)
  );

  assign hs1 = gateQ[G_HS1];
  assign ls1 = gateQ[G_LS1];
  assign hs2 = gateQ[G_HS2];
  assign ls2 = gateQ[G_LS2];

  // R1: disabling drops every gate on the next edge
  p_disable_off_r1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (gateQ == '0));

  // R10: a raised fault flag never coexists with an active gate
  p_fault_gates_off_r10: assert property (@(posedge clk) disable iff (rst)
    fault |-> (gateQ == '0));
endmodule

// File: tb/tb_hbridge_gate_seq.sv
module tb_hbridge_gate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W       = 8;
  localparam int BLANK      = 24;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            enable = 1'b0;
  logic            dir = 1'b0;
  logic            pwm = 1'b0;
  logic [3:0]      desat = '0;
  logic            supplyLow = 1'b0;
  logic [DT_W-1:0] deadCycles = '0;
  logic            hs1, ls1, hs2, ls2, fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_seq #(.DT_W(DT_W), .BLANK_CYC(BLANK)) dut (
    .clk(clk), .rst(rst), .enable(enable), .dir(dir), .pwm(pwm),
    .desat(desat), .supplyLow(supplyLow), .deadCycles(deadCycles),
    .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2), .fault(fault)
  );

  function automatic logic [3:0] expPat(input logic d, input logic p);
    // packed as {hs1, ls1, hs2, ls2}
    return d ? {~p, p, 1'b1, 1'b0} : {1'b1, 1'b0, ~p, p};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] expG, input logic expF);
    logic [3:0] act;
    act = {hs1, ls1, hs2, ls2};
    checks++;
    if (act !== expG || fault !== expF) begin
      errors++;
      $display("FAIL %s gates=%b fault=%b expected gates=%b fault=%b",
               req, act, fault, expG, expF);
    end
  endtask

  task automatic chkVal(input string req, input int act, input int expV);
    checks++;
    if (act != expV) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expV);
    end
  endtask

  // Count negedges until the selected gate reaches the level given.
  task automatic latency(input int idx, input logic lvl, output int n);
    logic [3:0] g;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      g = {hs1, ls1, hs2, ls2};
    end while (g[3-idx] !== lvl && n < 200);
  endtask

  task automatic t_reset;
    chk("R1 reset", 4'b0000, 1'b0);
  endtask

  task automatic t_disabled;
    for (int k = 0; k < 4; k++) begin
      dir = k[1]; pwm = k[0];
      cyc(8);
      chk("R1 disabled", 4'b0000, 1'b0);
    end
  endtask

  task automatic t_patterns;
    enable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      dir = k[1]; pwm = k[0];
      cyc(8);
      chk(k[1] ? "R3 dir1 pattern" : "R2 dir0 pattern", expPat(k[1], k[0]), 1'b0);
    end
  endtask

  task automatic t_deadtime(input int d);
    int n;
    deadCycles = DT_W'(d);
    dir = 1'b0; pwm = 1'b0;
    cyc(20 + d);
    pwm = 1'b1;
    latency(3, 1'b1, n);          // ls2 on
    chkVal("R4 turn-on latency", n, 3 + d);
    cyc(20 + d);
    pwm = 1'b0;
    latency(3, 1'b0, n);          // ls2 off
    chkVal("R4 turn-off latency", n, 3);
    cyc(20 + d);
    chk("R6 settled after dead time", expPat(1'b0, 1'b0), 1'b0);
  endtask

  task automatic t_dir_edge;
    int n;
    deadCycles = DT_W'(5);
    dir = 1'b0; pwm = 1'b1;
    cyc(30);
    dir = 1'b1;
    latency(1, 1'b1, n);          // ls1 on
    chkVal("R5 dir change starts dead time", n, 8);
    cyc(30);
    chk("R5 dir1 settled", expPat(1'b1, 1'b1), 1'b0);
  endtask

  task automatic t_full_duty;
    logic [3:0] first;
    int toggles;
    deadCycles = '0;
    dir = 1'b1; pwm = 1'b1;
    cyc(10);
    first = {hs1, ls1, hs2, ls2};
    toggles = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if ({hs1, ls1, hs2, ls2} !== first) toggles++;
    end
    chkVal("R6 full duty no glitch", toggles, 0);
    chk("R6 full duty pattern", expPat(1'b1, 1'b1), 1'b0);
  endtask

  task automatic t_desat_off_gate;
    dir = 1'b0; pwm = 1'b1;
    cyc(40);
    desat = 4'b0010;              // ls1, which is off
    cyc(60);
    chk("R7 desat on off gate ignored", expPat(1'b0, 1'b1), 1'b0);
    desat = '0;
    cyc(5);
  endtask

  task automatic t_short;
    // ls2 on long past blanking: short trips quickly
    dir = 1'b0; pwm = 1'b1;
    cyc(BLANK + 20);
    desat = 4'b1000;
    cyc(6);
    chk("R8 short trips", 4'b0000, 1'b1);
    dir = 1'b1;
    cyc(10);
    dir = 1'b0;
    desat = 4'b0000;
    cyc(10);
    chk("R8 latched through dir and desat removal", 4'b0000, 1'b1);
    pwm = 1'b0;
    cyc(5);
    chk("R8 pulse edge restores", expPat(1'b0, 1'b0), 1'b0);
    // re-arm with desat present: blanking holds it off, then it trips
    desat = 4'b1000;
    cyc(10);
    pwm = 1'b1;
    cyc(3 + BLANK - 2);
    chk("R7 blanked after turn-on", expPat(1'b0, 1'b1), 1'b0);
    cyc(6);
    chk("R7 trip after blanking", 4'b0000, 1'b1);
    desat = '0;
    pwm = 1'b0;
    cyc(6);
    chk("R8 cleared again", expPat(1'b0, 1'b0), 1'b0);
  endtask

  task automatic t_supply;
    dir = 1'b1; pwm = 1'b0;
    cyc(10);
    supplyLow = 1'b1;
    cyc(2);
    chk("R9 not yet through synchronizer", expPat(1'b1, 1'b0), 1'b0);
    cyc(1);
    chk("R9 supply low immediate", 4'b0000, 1'b1);
    cyc(20);
    chk("R10 held while low", 4'b0000, 1'b1);
    supplyLow = 1'b0;
    cyc(3);
    chk("R9 clears with condition", expPat(1'b1, 1'b0), 1'b0);
  endtask

  task automatic t_disable_running;
    dir = 1'b0; pwm = 1'b1;
    cyc(10);
    enable = 1'b0;
    cyc(2);
    chk("R1 enable dropped", 4'b0000, 1'b0);
    pwm = 1'b0;
    cyc(8);
    chk("R1 stays off on pwm change", 4'b0000, 1'b0);
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_disabled();
    t_patterns();
    t_deadtime(0);
    t_deadtime(5);
    t_deadtime(12);
    t_dir_edge();
    t_full_duty();
    t_desat_off_gate();
    t_short();
    t_supply();
    t_disable_running();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule